// File: doc/BRIEF.md
# Banked Memory Bus Arbiter

This block chooses which of several requesters (cache-miss port, DMA ports, dirty-line write-back buffer) drives the next transfer on a memory bus that serves several banks. Each requester presents a request with a 4-bit priority, a target bank, a write flag, a refill flag and an address. The requester holds it until the grant is accepted, and drops it in the cycle after acceptance. The arbiter applies three filters in order. It first removes requests whose bank is blocked. It then keeps only writes if any write is eligible. Finally it keeps the highest priority class, and inside that class the requester served least recently wins.

The grant is a valid/ready handshake toward the memory controller, and it is combinational while the arbiter is in state ARB. There are three states. ARB arbitrates every cycle. PEND holds a presented grant unchanged until the controller accepts it. BURST keeps the bus reserved after an accepted cache-line refill. The transitions are: ARB to PEND (grant offered but not accepted), ARB to BURST (refill accepted at once), PEND to ARB (accepted non-refill, or timeout), PEND to BURST (refill accepted after waiting) and BURST to ARB (window over).

The memory controller requests a refresh hold for one bank through a second valid/ready handshake, and that bank alone stops being served for a fixed time. A grant that waits too long is withdrawn. The arbiter then raises an interrupt pulse and logs the address for software.

Top module: `mbank_arbiter`

## Requirements
- R1: After reset no grant is offered while no request is valid, the interrupt is low, the logged address reads 0, and a refresh hold is accepted at once (rfsh_ready high).
- R2: The effective priority classes are: values 4 to 15 critical, 2 to 3 normal, 0 to 1 background. Among eligible candidates only the highest class present can win.
- R3: Within the winning class the least recently served requester wins. After reset a lower index counts as less recently served. A requester whose grant is accepted becomes the most recently served.
- R4: When prio_boost[i] is high, requester i is treated as critical whatever its priority field holds.
- R5: In state ARB an eligible request is granted in the same cycle it is presented, with gnt_id, gnt_addr, gnt_bank and gnt_write taken from that requester.
- R6: In the cycle after a grant to bank b is accepted, no grant to bank b is offered. Requests to other banks remain eligible.
- R7: After an accepted grant with the refill flag set, gnt_valid stays low for the next 3 cycles, a 4-cycle bus window in total.
- R8: rfsh_ready is high when the bank on rfsh_bank is not refreshing. After a refresh handshake that bank gets no grant for exactly the next 8 cycles, while other banks keep being served.
- R9: If any eligible request is a write, the winner is a write, whatever the class of the reads.
- R10: While a grant waits for gnt_ready, gnt_id, gnt_addr, gnt_bank and gnt_write stay unchanged.
- R11: A grant left unaccepted for 17 consecutive cycles, that is more than 16 wait states, is withdrawn. tmo_irq is then high for exactly one cycle, in the cycle after the last wait.
- R12: tmo_addr captures the address of the first timed-out grant and keeps it through later timeouts until tmo_clr. tmo_clr resets it to 0 and takes precedence over a capture in the same cycle.
- R13: When requesters of one class compete without pause on separate banks, each one is granted in turn and none starves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Request pending, one bit per requester |
| req_prio | input | N_REQ*PRIO_W | Priority field per requester |
| req_bank | input | N_REQ*BANK_W | Target bank per requester |
| req_addr | input | N_REQ*ADDR_W | Transfer address per requester |
| req_write | input | N_REQ | 1 = write (write-back), 0 = read |
| req_refill | input | N_REQ | 1 = cache-line refill needing the burst window |
| prio_boost | input | N_REQ | Per-port control: force the critical class |
| gnt_valid | output | 1 | Grant offered |
| gnt_ready | input | 1 | Memory controller accepts the grant |
| gnt_id | output | ID_W | Index of the granted requester |
| gnt_addr | output | ADDR_W | Address of the granted transfer |
| gnt_bank | output | BANK_W | Bank of the granted transfer |
| gnt_write | output | 1 | Direction of the granted transfer |
| rfsh_valid | input | 1 | Refresh hold requested |
| rfsh_bank | input | BANK_W | Bank to hold for refresh |
| rfsh_ready | output | 1 | Refresh hold accepted |
| tmo_clr | input | 1 | Clear the logged timeout address |
| tmo_irq | output | 1 | One-cycle timeout interrupt |
| tmo_addr | output | ADDR_W | Address of the first timed-out grant |

## Verification
The hardest situation to reach is the wait-state timeout. A random controller almost never leaves a grant unaccepted for 17 cycles in a row, so the rule that the first failing address is kept is hard to reach as well. A directed sequence therefore holds gnt_ready low across two separate timeouts with different addresses, and then clears the log. A cycle model then follows long random runs. In these runs held requests, refills, writes, boosts, refresh holds and a controller that stalls often all overlap, so burst windows, bank gaps and refresh stalls fall together.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int CRIT_MIN = 4;
    localparam int NORM_MIN = 2;

    typedef enum logic [1:0] {CLS_BG = 2'd0, CLS_NORM = 2'd1, CLS_CRIT = 2'd2} cls_e;
    typedef enum logic [1:0] {ST_ARB = 2'd0, ST_PEND = 2'd1, ST_BURST = 2'd2} st_e;

    function automatic cls_e prio_class(input logic [7:0] p, input logic boost);
        if (boost || p >= 8'(CRIT_MIN)) return CLS_CRIT;
        else if (p >= 8'(NORM_MIN))     return CLS_NORM;
        else                            return CLS_BG;
    endfunction
endpackage

// File: rtl/arb_bank_track.sv
module arb_bank_track #(
    parameter int N_BANK   = 4,
    parameter int RFSH_CYC = 8,
    localparam int BANK_W  = (N_BANK > 1) ? $clog2(N_BANK) : 1,
    localparam int RC_W    = $clog2(RFSH_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_vld,
    input  logic [BANK_W-1:0] use_bank,
    input  logic              rfsh_valid,
    input  logic [BANK_W-1:0] rfsh_bank,
    output logic              rfsh_ready,
    output logic [N_BANK-1:0] blocked
);
    logic [RC_W-1:0] rcnt [N_BANK];
    logic            busy [N_BANK];

    assign rfsh_ready = (rcnt[rfsh_bank] == '0);

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rcnt[b] <= '0;
                busy[b] <= 1'b0;
            end else begin
                busy[b] <= use_vld && (use_bank == BANK_W'(b));
                if (rfsh_valid && rfsh_ready && (rfsh_bank == BANK_W'(b)))
                    rcnt[b] <= RC_W'(RFSH_CYC);
                else if (rcnt[b] != '0)
                    rcnt[b] <= rcnt[b] - 1'b1;
            end
        end
        assign blocked[b] = busy[b] || (rcnt[b] != '0);

        AST_RFSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            (rfsh_valid && rfsh_ready && rfsh_bank == BANK_W'(b)) |=> blocked[b]); // R8
        AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (use_vld && use_bank == BANK_W'(b)) |=> blocked[b]); // R6
    end
endmodule

// File: rtl/arb_age.sv
module arb_age #(
    parameter int N_REQ = 4,
    localparam int ID_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd,
    input  logic [ID_W-1:0]        upd_id,
    output logic [N_REQ*N_REQ-1:0] older
);
    // older[i*N_REQ+j] = 1 : requester i was served less recently than j
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REQ; i++)
                for (int j = 0; j < N_REQ; j++)
                    older[i*N_REQ+j] <= (i < j);
        end else if (upd) begin
            for (int i = 0; i < N_REQ; i++)
                for (int j = 0; j < N_REQ; j++)
                    if (i != j) begin
                        if (upd_id == ID_W'(i))      older[i*N_REQ+j] <= 1'b0;
                        else if (upd_id == ID_W'(j)) older[i*N_REQ+j] <= 1'b1;
                    end
        end
    end

    for (genvar i = 0; i < N_REQ; i++) begin : g_chk
        AST_SERVED_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && upd_id == ID_W'(i)) |=> (older[i*N_REQ +: N_REQ] == '0)); // R3
    end
endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int N_BANK = 4,
    parameter int PRIO_W = 4,
    localparam int ID_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1,
    localparam int BANK_W = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
    input  logic [N_REQ-1:0]        req_valid,
    input  logic [N_REQ-1:0]        req_write,
    input  logic [N_REQ-1:0]        prio_boost,
    input  logic [N_REQ*PRIO_W-1:0] req_prio,
    input  logic [N_REQ*BANK_W-1:0] req_bank,
    input  logic [N_BANK-1:0]       blocked,
    input  logic [N_REQ*N_REQ-1:0]  older,
    output logic                    win_vld,
    output logic [ID_W-1:0]         win_id
);
    logic [N_REQ-1:0] elig, cand, fin, win;
    cls_e             cls [N_REQ];
    cls_e             top;

    for (genvar i = 0; i < N_REQ; i++) begin : g_req
        assign elig[i] = req_valid[i] && !blocked[req_bank[i*BANK_W +: BANK_W]];
        assign cls[i]  = prio_class(8'(req_prio[i*PRIO_W +: PRIO_W]), prio_boost[i]);
        assign fin[i]  = cand[i] && (cls[i] == top);
    end

    // writes drain ahead of reads
    always_comb cand = (|(elig & req_write)) ? (elig & req_write) : elig;

    always_comb begin
        top = CLS_BG;
        for (int i = 0; i < N_REQ; i++)
            if (cand[i] && cls[i] > top) top = cls[i];
    end

    always_comb begin
        for (int i = 0; i < N_REQ; i++) begin
            win[i] = fin[i];
            for (int j = 0; j < N_REQ; j++)
                if (j != i && fin[j] && !older[i*N_REQ+j]) win[i] = 1'b0;
        end
    end

    always_comb begin
        win_vld = |win;
        win_id  = '0;
        for (int i = 0; i < N_REQ; i++)
            if (win[i]) win_id = ID_W'(i);
    end
endmodule

// File: rtl/mbank_arbiter.sv
module mbank_arbiter
    import arb_pkg::*;
#(
    parameter int N_REQ     = 4,
    parameter int N_BANK    = 4,
    parameter int ADDR_W    = 16,
    parameter int PRIO_W    = 4,
    parameter int TO_LIMIT  = 16,
    parameter int BURST_LEN = 4,
    parameter int RFSH_CYC  = 8,
    localparam int ID_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1,
    localparam int BANK_W = (N_BANK > 1) ? $clog2(N_BANK) : 1,
    localparam int WC_W   = $clog2(TO_LIMIT + 1),
    localparam int BC_W   = $clog2(BURST_LEN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_REQ-1:0]        req_valid,
    input  logic [N_REQ*PRIO_W-1:0] req_prio,
    input  logic [N_REQ*BANK_W-1:0] req_bank,
    input  logic [N_REQ*ADDR_W-1:0] req_addr,
    input  logic [N_REQ-1:0]        req_write,
    input  logic [N_REQ-1:0]        req_refill,
    input  logic [N_REQ-1:0]        prio_boost,
    output logic                    gnt_valid,
    input  logic                    gnt_ready,
    output logic [ID_W-1:0]         gnt_id,
    output logic [ADDR_W-1:0]       gnt_addr,
    output logic [BANK_W-1:0]       gnt_bank,
    output logic                    gnt_write,
    input  logic                    rfsh_valid,
    input  logic [BANK_W-1:0]       rfsh_bank,
    output logic                    rfsh_ready,
    input  logic                    tmo_clr,
    output logic                    tmo_irq,
    output logic [ADDR_W-1:0]       tmo_addr
);
    st_e               st, st_nx;
    logic [ID_W-1:0]   lat_id;
    logic [ADDR_W-1:0] lat_addr;
    logic [BANK_W-1:0] lat_bank;
    logic              lat_write, lat_refill, tmo_held;
    logic [WC_W-1:0]   wcnt;
    logic [BC_W-1:0]   bcnt;
    logic              win_vld, g_refill, acc, to_ev;
    logic [ID_W-1:0]   win_id;
    logic [N_BANK-1:0] blocked;
    logic [N_REQ*N_REQ-1:0] older;
    logic [ADDR_W-1:0] addr_a [N_REQ];
    logic [BANK_W-1:0] bank_a [N_REQ];

    for (genvar i = 0; i < N_REQ; i++) begin : g_unpack
        assign addr_a[i] = req_addr[i*ADDR_W +: ADDR_W];
        assign bank_a[i] = req_bank[i*BANK_W +: BANK_W];
    end

    arb_bank_track #(.N_BANK(N_BANK), .RFSH_CYC(RFSH_CYC)) i_banks (
        .clk(clk), .rst_n(rst_n), .use_vld(acc), .use_bank(gnt_bank),
        .rfsh_valid(rfsh_valid), .rfsh_bank(rfsh_bank), .rfsh_ready(rfsh_ready),
        .blocked(blocked));

    arb_age #(.N_REQ(N_REQ)) i_age (
        .clk(clk), .rst_n(rst_n), .upd(acc), .upd_id(gnt_id), .older(older));

    arb_pick #(.N_REQ(N_REQ), .N_BANK(N_BANK), .PRIO_W(PRIO_W)) i_pick (
        .req_valid(req_valid), .req_write(req_write), .prio_boost(prio_boost),
        .req_prio(req_prio), .req_bank(req_bank), .blocked(blocked),
        .older(older), .win_vld(win_vld), .win_id(win_id));

    // outputs
    always_comb begin
        gnt_valid = 1'b0;
        gnt_id    = win_id;
        gnt_addr  = addr_a[win_id];
        gnt_bank  = bank_a[win_id];
        gnt_write = req_write[win_id];
        g_refill  = req_refill[win_id];
        unique case (st)
            ST_ARB:   gnt_valid = win_vld;
            ST_PEND: begin
                gnt_valid = 1'b1;
                gnt_id    = lat_id;
                gnt_addr  = lat_addr;
                gnt_bank  = lat_bank;
                gnt_write = lat_write;
                g_refill  = lat_refill;
            end
            ST_BURST: gnt_valid = 1'b0;
            default:  gnt_valid = 1'b0;
        endcase
    end

    assign acc   = gnt_valid && gnt_ready;
    assign to_ev = (st == ST_PEND) && !gnt_ready && (wcnt == WC_W'(TO_LIMIT));

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_ARB:
                if (win_vld) begin
                    if (!gnt_ready)                       st_nx = ST_PEND;
                    else if (g_refill && BURST_LEN > 1)   st_nx = ST_BURST;
                end
            ST_PEND:
                if (gnt_ready) st_nx = (g_refill && BURST_LEN > 1) ? ST_BURST : ST_ARB;
                else if (to_ev) st_nx = ST_ARB;
            ST_BURST:
                if (bcnt == BC_W'(1)) st_nx = ST_ARB;
            default: st_nx = ST_ARB;
        endcase
    end

    // state register and its companions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_ARB;
            lat_id     <= '0;
            lat_addr   <= '0;
            lat_bank   <= '0;
            lat_write  <= 1'b0;
            lat_refill <= 1'b0;
            wcnt       <= '0;
            bcnt       <= '0;
            tmo_irq    <= 1'b0;
            tmo_addr   <= '0;
            tmo_held   <= 1'b0;
        end else begin
            st      <= st_nx;
            tmo_irq <= to_ev;
            if (st == ST_ARB) begin
                lat_id     <= gnt_id;
                lat_addr   <= gnt_addr;
                lat_bank   <= gnt_bank;
                lat_write  <= gnt_write;
                lat_refill <= g_refill;
                wcnt       <= WC_W'(1);
            end else if (st == ST_PEND && !gnt_ready) begin
                wcnt <= wcnt + 1'b1;
            end
            if (st_nx == ST_BURST && st != ST_BURST) bcnt <= BC_W'(BURST_LEN - 1);
            else if (st == ST_BURST)                 bcnt <= bcnt - 1'b1;
            if (tmo_clr) begin
                tmo_addr <= '0;
                tmo_held <= 1'b0;
            end else if (to_ev && !tmo_held) begin
                tmo_addr <= gnt_addr;
                tmo_held <= 1'b1;
            end
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_ready && !to_ev) |=> (gnt_valid && $stable(gnt_id) && $stable(gnt_addr))); // R10
    AST_BURST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && g_refill) |=> !gnt_valid); // R7
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |=> !tmo_irq); // R11
    AST_NO_SAME_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !(gnt_valid && gnt_bank == $past(gnt_bank))); // R6
    AST_GNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARB && gnt_valid) |-> req_valid[gnt_id]); // R5
endmodule

// File: tb/test_mbank_arbiter.sv
module test_mbank_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  req_valid, req_write, req_refill, prio_boost;
    logic [15:0] req_prio;
    logic [7:0]  req_bank;
    logic [63:0] req_addr;
    logic        gnt_ready, gnt_valid, gnt_write;
    logic [1:0]  gnt_id, gnt_bank;
    logic [15:0] gnt_addr;
    logic        rfsh_valid, rfsh_ready;
    logic [1:0]  rfsh_bank;
    logic        tmo_clr, tmo_irq;
    logic [15:0] tmo_addr;

    always #4 clk = ~clk;

    mbank_arbiter i_mbank_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
        .req_bank(req_bank), .req_addr(req_addr), .req_write(req_write),
        .req_refill(req_refill), .prio_boost(prio_boost), .gnt_valid(gnt_valid),
        .gnt_ready(gnt_ready), .gnt_id(gnt_id), .gnt_addr(gnt_addr),
        .gnt_bank(gnt_bank), .gnt_write(gnt_write), .rfsh_valid(rfsh_valid),
        .rfsh_bank(rfsh_bank), .rfsh_ready(rfsh_ready), .tmo_clr(tmo_clr),
        .tmo_irq(tmo_irq), .tmo_addr(tmo_addr));

    int  n_chk = 0, n_bad = 0;
    bit  done = 0;

    // reference model state
    int          m_st, m_lid, m_wcnt, m_bcnt;
    bit          m_old [4][4];
    bit [3:0]    m_busy;
    int          m_rcnt [4];
    logic [15:0] m_toaddr;
    bit          m_held, m_irq;
    bit          e_v, e_rr;
    int          e_id;
    int          last_id;
    bit          last_acc;
    int          gcount [4];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int bk(int i);   return int'(req_bank[i*2 +: 2]);  endfunction
    function automatic logic [15:0] ad(int i); return req_addr[i*16 +: 16]; endfunction
    function automatic int cls_of(int i);
        int p = int'(req_prio[i*4 +: 4]);
        if (prio_boost[i] || p >= 4) return 2;
        if (p >= 2) return 1;
        return 0;
    endfunction

    task automatic m_reset();
        m_st = 0; m_lid = 0; m_wcnt = 0; m_bcnt = 0; m_busy = '0;
        m_toaddr = '0; m_held = 0; m_irq = 0;
        for (int i = 0; i < 4; i++) begin
            m_rcnt[i] = 0;
            for (int j = 0; j < 4; j++) m_old[i][j] = (i < j);
        end
    endtask

    task automatic m_eval();
        bit [3:0] el, cd;
        int top;
        e_v = 0; e_id = 0;
        if (m_st == 1) begin
            e_v = 1; e_id = m_lid;
        end else if (m_st == 0) begin
            for (int i = 0; i < 4; i++)
                el[i] = req_valid[i] && !m_busy[bk(i)] && m_rcnt[bk(i)] == 0;
            cd = ((el & req_write) != 0) ? (el & req_write) : el;
            top = -1;
            for (int i = 0; i < 4; i++) if (cd[i] && cls_of(i) > top) top = cls_of(i);
            for (int i = 0; i < 4; i++) if (cd[i] && cls_of(i) == top) begin
                bit ok = 1;
                for (int j = 0; j < 4; j++)
                    if (j != i && cd[j] && cls_of(j) == top && !m_old[i][j]) ok = 0;
                if (ok) begin e_v = 1; e_id = i; end
            end
        end
        e_rr = (m_rcnt[rfsh_bank] == 0);
    endtask

    task automatic m_step();
        bit acc = e_v && gnt_ready;
        int ab = bk(e_id);
        bit rf = req_refill[e_id];
        bit to = 0;
        for (int b = 0; b < 4; b++)
            if (rfsh_valid && e_rr && int'(rfsh_bank) == b) m_rcnt[b] = 8;
            else if (m_rcnt[b] > 0) m_rcnt[b]--;
        m_busy = '0;
        if (acc) begin
            m_busy[ab] = 1;
            for (int j = 0; j < 4; j++) if (j != e_id) begin
                m_old[e_id][j] = 0; m_old[j][e_id] = 1;
            end
        end
        case (m_st)
            0: if (e_v) begin
                   if (gnt_ready) begin m_st = rf ? 2 : 0; m_bcnt = 3; end
                   else begin m_st = 1; m_lid = e_id; m_wcnt = 1; end
               end
            1: if (gnt_ready) begin m_st = rf ? 2 : 0; m_bcnt = 3; end
               else if (m_wcnt == 16) begin to = 1; m_st = 0; end
               else m_wcnt++;
            default: if (m_bcnt == 1) m_st = 0; else m_bcnt--;
        endcase
        if (tmo_clr) begin m_toaddr = '0; m_held = 0; end
        else if (to && !m_held) begin m_toaddr = ad(e_id); m_held = 1; end
        m_irq = to;
        last_acc = acc; last_id = e_id;
    endtask

    // called just after a falling edge with inputs set; returns at next falling edge
    task automatic step();
        #1;
        m_eval();
        chk(gnt_valid == e_v, "R5 R6 R7 R8 gnt_valid", gnt_valid, e_v);
        if (e_v && gnt_valid) begin
            chk(gnt_id == e_id[1:0], "R2 R3 R4 R9 gnt_id", gnt_id, e_id);
            chk(gnt_addr == ad(e_id), "R5 R10 gnt_addr", gnt_addr, ad(e_id));
            chk(gnt_bank == bk(e_id) && gnt_write == req_write[e_id], "R5 R10 bank/write",
                {gnt_bank, gnt_write}, {bk(e_id), req_write[e_id]});
            if (gnt_ready) gcount[gnt_id]++;
        end
        chk(rfsh_ready == e_rr, "R8 rfsh_ready", rfsh_ready, e_rr);
        chk(tmo_irq == m_irq, "R11 tmo_irq", tmo_irq, m_irq);
        chk(tmo_addr == m_toaddr, "R12 tmo_addr", tmo_addr, m_toaddr);
        m_step();
        @(negedge clk);
    endtask

    task automatic set_req(int i, int prio, int bank, logic [15:0] a, bit w, bit rf);
        req_valid[i] = 1'b1;
        req_prio[i*4 +: 4] = 4'(prio);
        req_bank[i*2 +: 2] = 2'(bank);
        req_addr[i*16 +: 16] = a;
        req_write[i] = w;
        req_refill[i] = rf;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = '0; req_write = '0; req_refill = '0; prio_boost = '0;
        req_prio = '0; req_bank = '0; req_addr = '0;
        gnt_ready = 1'b0; rfsh_valid = 1'b0; rfsh_bank = '0; tmo_clr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_reset();
        last_acc = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        do_reset();
        // R1 reset state
        #1;
        chk(!gnt_valid && !tmo_irq, "R1 grant/irq idle", {gnt_valid, tmo_irq}, 0);
        chk(tmo_addr == 16'h0, "R1 tmo_addr", tmo_addr, 0);
        chk(rfsh_ready, "R1 rfsh_ready", rfsh_ready, 1);
        @(negedge clk);

        // R11 / R12 directed timeouts
        set_req(0, 2, 0, 16'h1234, 0, 0);
        for (int k = 0; k < 17; k++) begin
            #1 chk(gnt_valid && !tmo_irq, "R11 grant held before timeout", {gnt_valid, tmo_irq}, 2'b10);
            step();
        end
        req_valid[0] = 1'b0;
        #1 chk(tmo_irq && !gnt_valid, "R11 irq after 17 waits", {tmo_irq, gnt_valid}, 2'b10);
        chk(tmo_addr == 16'h1234, "R12 first address", tmo_addr, 16'h1234);
        step();
        set_req(1, 2, 1, 16'h0bee, 0, 0);
        #1 chk(!tmo_irq, "R11 single-cycle pulse", tmo_irq, 0);
        step();
        for (int k = 0; k < 16; k++) step();
        req_valid[1] = 1'b0;
        #1 chk(tmo_irq && tmo_addr == 16'h1234, "R12 first address kept", tmo_addr, 16'h1234);
        step();
        tmo_clr = 1'b1;
        step();
        tmo_clr = 1'b0;
        #1 chk(tmo_addr == 16'h0, "R12 cleared", tmo_addr, 0);
        step();

        // R13 fairness within one class
        do_reset();
        for (int i = 0; i < 4; i++) begin
            set_req(i, 2 + (i & 1), i, 16'(16'h100 * i), 0, 0);
            gcount[i] = 0;
        end
        gnt_ready = 1'b1;
        repeat (40) step();
        for (int i = 0; i < 4; i++)
            chk(gcount[i] >= 9, "R13 no starvation", gcount[i], 9);

        // random traffic against the model
        do_reset();
        for (int c = 0; c < 6000; c++) begin
            for (int i = 0; i < 4; i++) begin
                if (last_acc && last_id == i) req_valid[i] = 1'b0;
                else if (!req_valid[i] && $urandom % 3 == 0)
                    set_req(i, int'($urandom % 16), int'($urandom % 4), 16'($urandom),
                            ($urandom % 3) == 0, ($urandom % 5) == 0);
            end
            if (c % 25 == 0) prio_boost = 4'($urandom);
            gnt_ready  = ($urandom % 4) != 0;
            rfsh_valid = ($urandom % 7) == 0;
            rfsh_bank  = 2'($urandom);
            tmo_clr    = ($urandom % 60) == 0;
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule